// File: doc/BRIEF.md
# Serial DAC Write Controller

This block sits in the system clock domain. It turns a parallel request into a 24-bit write on a three-wire serial DAC port. A request carries a 16-bit code and a 2-bit operating mode, with a valid/ready handshake. The block drives an active-low frame strobe (`sync_n`), a serial clock (`sclk`) and serial data (`sdo`).

The serial clock rests low. Data changes only on rising edges, so it is stable at every falling edge, where the DAC samples it. The following are fixed at elaboration time, counted in system clock cycles:
- the serial clock half period;
- the minimum strobe-high time before a frame;
- the idle level of the strobe;
- an optional byte-burst mode.

With a low idle level, the strobe stays low between frames to save power. It is then pulsed high for the gap time in front of each new frame. In byte-burst mode the 24 bits go out as three bursts of eight clocks under one strobe-low period, which mimics a host that can only shift whole bytes.

Top module: `dacwr_ctrl`

## Requirements
- R1: After reset `sclk` and `done` are 0, `req_ready` is 1, and `sync_n` sits at its idle level: 1 when IDLE_LOW=0 and 0 when IDLE_LOW=1.
- R2: Each accepted request produces a frame of 24 bits, most significant first. The frame holds six zero bits, then `req_mode[1]`, `req_mode[0]`, then `req_code[15]` down to `req_code[0]`. Each bit is taken at a falling edge of `sclk`.
- R3: `sdo` never changes at the system clock edge where `sclk` falls.
- R4: `sclk` stays high for exactly HALF_DIV cycles per pulse. Between two clocks of the same burst it stays low for exactly HALF_DIV cycles.
- R5: Before every frame except the first one after reset, `sync_n` has been high for at least GAP_CYC cycles. With IDLE_LOW=1 this pre-frame pulse lasts exactly GAP_CYC cycles.
- R6: `sclk` is low whenever `sync_n` is high. Exactly 24 falling edges of `sclk` occur between the fall of `sync_n` and `done`.
- R7: The first falling edge of `sclk` in a frame comes exactly 2*HALF_DIV cycles after `sync_n` falls.
- R8: `req_ready` is 0 while `sclk` is high and from acceptance onward. With IDLE_LOW=0 it returns to 1 exactly GAP_CYC cycles after `done`.
- R9: `done` is a one-cycle pulse, raised the cycle after the 24th falling edge of `sclk`.
- R10: With IDLE_LOW=0, `sync_n` is back high when `done` is seen. With IDLE_LOW=1, `sync_n` stays low after `done` and for as long as the block waits for a request.
- R11: With BYTE_MODE=1, after the 8th and 16th falling edges `sclk` stays low for BYTE_GAP+HALF_DIV cycles while `sync_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_code | input | 16 | DAC code to send |
| req_mode | input | 2 | Operating-mode bits placed ahead of the code |
| sync_n | output | 1 | Active-low frame strobe |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data, valid at `sclk` falling edges |
| done | output | 1 | One-cycle pulse at frame completion |

## Verification
The hardest situations to reach from the ports involve the strobe and the bursts.
- Back-to-back frames test the strobe gap. The low-idle strobe must rise for exactly the gap before the next frame, after sitting low since the previous one.
- The pause between byte bursts must not be mistaken for the end of a frame.

The bench builds two instances side by side:
- one with a high idle level and word bursts;
- one with a low idle level and byte bursts.

It feeds each a queue of requests as soon as it turns ready. Codes sit at the extremes and at the major carry, and every mode value is used. The monitors measure every phase length, along with the words collected at the falling edges.

// File: rtl/dacwr_ctrl.sv
module dacwr_ctrl #(
  parameter int HALF_DIV  = 3,
  parameter int GAP_CYC   = 4,
  parameter int BYTE_GAP  = 8,
  parameter bit BYTE_MODE = 1'b0,
  parameter bit IDLE_LOW  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_code,
  input  logic [1:0]  req_mode,
  output logic        sync_n,
  output logic        sclk,
  output logic        sdo,
  output logic        done
);
  localparam int FRAME_BITS = 24;
  localparam int PAD_BITS   = FRAME_BITS - 18;
  localparam int MAX_HG     = (HALF_DIV > GAP_CYC) ? HALF_DIV : GAP_CYC;
  localparam int CNT_MAX    = (MAX_HG > BYTE_GAP) ? MAX_HG : BYTE_GAP;
  localparam int CW         = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_LEAD, S_HI, S_LO, S_PAUSE, S_END} st_t;

  st_t                   st;
  logic [CW-1:0]         cnt, lim;
  logic [4:0]            nbit;
  logic [FRAME_BITS-1:0] sr;
  logic                  tick;

  always_comb begin
    case (st)
      S_GAP:   lim = CW'(GAP_CYC - 1);
      S_PAUSE: lim = CW'(BYTE_GAP - 1);
      default: lim = CW'(HALF_DIV - 1);
    endcase
  end

  assign tick      = (cnt == lim);
  assign req_ready = (st == S_IDLE);
  assign sdo       = sr[FRAME_BITS-1] & ~sync_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      nbit   <= '0;
      sr     <= '0;
      sync_n <= ~IDLE_LOW;
      sclk   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE || st == S_END || tick) cnt <= '0;
      else cnt <= cnt + 1'b1;
      case (st)
        S_IDLE:
          if (req_valid) begin
            sr   <= {{PAD_BITS{1'b0}}, req_mode, req_code};
            nbit <= '0;
            if (IDLE_LOW) begin
              st     <= S_GAP;
              sync_n <= 1'b1;
            end else begin
              st     <= S_LEAD;
              sync_n <= 1'b0;
            end
          end
        S_GAP:
          if (tick) begin
            if (IDLE_LOW) begin
              st     <= S_LEAD;
              sync_n <= 1'b0;
            end else begin
              st <= S_IDLE;
            end
          end
        S_LEAD:
          if (tick) begin
            sclk <= 1'b1;
            st   <= S_HI;
          end
        S_HI:
          if (tick) begin
            sclk <= 1'b0;
            nbit <= nbit + 1'b1;
            if (nbit == 5'(FRAME_BITS - 1)) st <= S_END;
            else if (BYTE_MODE && nbit[2:0] == 3'd7) st <= S_PAUSE;
            else st <= S_LO;
          end
        S_LO:
          if (tick) begin
            sclk <= 1'b1;
            sr   <= sr << 1;
            st   <= S_HI;
          end
        S_PAUSE:
          if (tick) begin
            sr <= sr << 1;
            st <= S_LEAD;
          end
        S_END: begin
          done <= 1'b1;
          if (IDLE_LOW) begin
            st <= S_IDLE;
          end else begin
            sync_n <= 1'b1;
            st     <= S_GAP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dacwr_ctrl_chk.sv
module dacwr_ctrl_chk #(
  parameter int HALF_DIV  = 3,
  parameter int GAP_CYC   = 4,
  parameter int BYTE_GAP  = 8,
  parameter bit BYTE_MODE = 1'b0,
  parameter bit IDLE_LOW  = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic sync_n,
  input logic sclk,
  input logic sdo,
  input logic done
);
  localparam int SAT = 1 << 20;

  logic sclk_q, sync_q, seen_rise, fall_now;
  int   fc, hi, lo, shi, slo, exp_lo;

  assign fall_now = sclk_q & ~sclk;

  always_comb begin
    if (BYTE_MODE && (fc % 8) == 0) exp_lo = BYTE_GAP + HALF_DIV;
    else exp_lo = HALF_DIV;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; sync_q <= 1'b1; seen_rise <= 1'b0;
      fc <= 0; hi <= 0; lo <= 0; shi <= 0; slo <= 0;
    end else begin
      sclk_q <= sclk;
      sync_q <= sync_n;
      if (sync_n && !sync_q) seen_rise <= 1'b1;
      if (sync_q && !sync_n) fc <= 0;
      else if (fall_now) fc <= fc + 1;
      hi  <= sclk   ? ((hi  < SAT) ? hi  + 1 : hi)  : 0;
      lo  <= !sclk  ? ((lo  < SAT) ? lo  + 1 : lo)  : 0;
      shi <= sync_n ? ((shi < SAT) ? shi + 1 : shi) : 0;
      slo <= !sync_n ? ((slo < SAT) ? slo + 1 : slo) : 0;
    end
  end

  assert_sdo_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(sdo));
  assert_high_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> hi == HALF_DIV);
  assert_low_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && fc != 0) |-> lo == exp_lo);
  assert_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sync_n) && seen_rise) |-> shi >= GAP_CYC);
  assert_quiet_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> !sclk);
  assert_edge_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fc == 24);
  assert_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk) && fc == 0) |-> slo == 2 * HALF_DIV);
  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !req_ready);
  assert_done_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fall_now));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sync_n == !IDLE_LOW));
endmodule

bind dacwr_ctrl dacwr_ctrl_chk #(
  .HALF_DIV(HALF_DIV), .GAP_CYC(GAP_CYC), .BYTE_GAP(BYTE_GAP),
  .BYTE_MODE(BYTE_MODE), .IDLE_LOW(IDLE_LOW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .sync_n(sync_n),
  .sclk(sclk), .sdo(sdo), .done(done)
);

// File: tb/dacwr_ctrl_tb_top.sv
module dacwr_mon #(
  parameter int HALF     = 3,
  parameter int GAP      = 4,
  parameter int BGAP     = 8,
  parameter bit BYTEM    = 1'b0,
  parameter bit IDLE_LOW = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic ready,
  input logic sync_n,
  input logic sclk,
  input logic sdo,
  input logic done
);
  int checks = 0;
  int fails  = 0;
  logic [23:0] exp_q[$];
  logic [23:0] got;
  logic [23:0] want;
  logic p_sclk, p_sync, p_done, seen_rise, seen_done;
  int nf, hi_run, lo_run, sh_run, since_sf, since_f, since_d;

  task automatic push(input logic [23:0] w);
    exp_q.push_back(w);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %m actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      p_sclk = sclk; p_sync = sync_n; p_done = 0; seen_rise = 0; seen_done = 0;
      nf = 0; hi_run = 0; lo_run = 0; sh_run = 0; since_sf = 0; since_f = 0; since_d = 0;
      got = '0;
    end else begin
      since_sf++; since_f++; since_d++;
      if (p_sync && !sync_n) begin
        if (IDLE_LOW) chk(sh_run == GAP, "R5", sh_run, GAP);
        else if (seen_rise) chk(sh_run >= GAP, "R5", sh_run, GAP);
        nf = 0; since_sf = 0;
      end
      if (sync_n && !p_sync) seen_rise = 1;
      sh_run = sync_n ? (p_sync ? sh_run + 1 : 1) : 0;
      if (sclk && !p_sclk) begin
        if (nf != 0) begin
          if (BYTEM && nf % 8 == 0) chk(lo_run == BGAP + HALF, "R11", lo_run, BGAP + HALF);
          else chk(lo_run == HALF, "R4", lo_run, HALF);
        end
        hi_run = 1;
      end else if (sclk) hi_run++;
      if (!sclk && p_sclk) begin
        chk(hi_run == HALF, "R4", hi_run, HALF);
        chk(sync_n == 1'b0, "R6", sync_n, 0);
        got = {got[22:0], sdo};
        nf++;
        if (nf == 1) chk(since_sf == 2 * HALF, "R7", since_sf, 2 * HALF);
        lo_run = 1; since_f = 0;
      end else if (!sclk) lo_run++;
      if (sclk) chk(ready == 1'b0, "R8", ready, 0);
      if (IDLE_LOW && ready) chk(sync_n == 1'b0, "R10", sync_n, 0);
      if (!IDLE_LOW && seen_done && ready && since_d >= 0) begin
        chk(since_d == GAP, "R8", since_d, GAP);
        seen_done = 0;
      end
      if (done) begin
        chk(!p_done, "R9", p_done, 0);
        chk(since_f == 1, "R9", since_f, 1);
        chk(nf == 24, "R6", nf, 24);
        chk(sync_n == !IDLE_LOW, "R10", sync_n, !IDLE_LOW);
        if (exp_q.size() == 0) chk(0, "R2", got, 0);
        else begin
          want = exp_q.pop_front();
          chk(got == want, "R2", got, want);
        end
        nf = 0; since_d = 0; seen_done = !IDLE_LOW;
      end
      p_sclk = sclk; p_sync = sync_n; p_done = done;
    end
  end
endmodule

module dacwr_ctrl_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic        va, vb, ra, rb, sa, sb, ka, kb, da, db, qa, qb;
  logic [15:0] ca, cb;
  logic [1:0]  ma, mb;
  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  dacwr_ctrl #(.HALF_DIV(2), .GAP_CYC(4), .BYTE_GAP(3), .BYTE_MODE(0), .IDLE_LOW(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(va), .req_ready(ra), .req_code(ca), .req_mode(ma),
    .sync_n(sa), .sclk(ka), .sdo(da), .done(qa));
  dacwr_ctrl #(.HALF_DIV(3), .GAP_CYC(5), .BYTE_GAP(4), .BYTE_MODE(1), .IDLE_LOW(1)) dut_b (
    .clk(clk), .rst_n(rst_n), .req_valid(vb), .req_ready(rb), .req_code(cb), .req_mode(mb),
    .sync_n(sb), .sclk(kb), .sdo(db), .done(qb));

  dacwr_mon #(.HALF(2), .GAP(4), .BGAP(3), .BYTEM(0), .IDLE_LOW(0)) mon_a (
    .clk(clk), .rst_n(rst_n), .ready(ra), .sync_n(sa), .sclk(ka), .sdo(da), .done(qa));
  dacwr_mon #(.HALF(3), .GAP(5), .BGAP(4), .BYTEM(1), .IDLE_LOW(1)) mon_b (
    .clk(clk), .rst_n(rst_n), .ready(rb), .sync_n(sb), .sclk(kb), .sdo(db), .done(qb));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d",
             checks + mon_a.checks + mon_b.checks, fails + mon_a.fails + mon_b.fails);
  endtask

  task automatic send(input bit which, input logic [15:0] code, input logic [1:0] mode);
    if (!which) begin
      mon_a.push({6'b0, mode, code});
      do @(negedge clk); while (!ra);
      va = 1; ca = code; ma = mode;
      @(negedge clk); va = 0;
      chk(ra == 1'b0, "R8", ra, 0);
    end else begin
      mon_b.push({6'b0, mode, code});
      do @(negedge clk); while (!rb);
      vb = 1; cb = code; mb = mode;
      @(negedge clk); vb = 0;
      chk(rb == 1'b0, "R8", rb, 0);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc == 100000 && !finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      report();
      $finish;
    end
  end

  initial begin
    va = 0; vb = 0; ca = '0; cb = '0; ma = '0; mb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sa == 1'b1, "R1", sa, 1);
    chk(sb == 1'b0, "R1", sb, 0);
    chk(ka == 1'b0 && kb == 1'b0, "R1", {ka, kb}, 0);
    chk(ra == 1'b1 && rb == 1'b1, "R1", {ra, rb}, 3);
    chk(qa == 1'b0 && qb == 1'b0, "R1", {qa, qb}, 0);
    fork
      begin
        send(0, 16'h0000, 2'b00);
        send(0, 16'hFFFF, 2'b11);
        send(0, 16'h7FFF, 2'b01);
        send(0, 16'h8000, 2'b10);
        send(0, 16'hA5C3, 2'b00);
      end
      begin
        send(1, 16'hFFFF, 2'b00);
        send(1, 16'h0001, 2'b11);
        send(1, 16'h8000, 2'b10);
        send(1, 16'h3C96, 2'b01);
      end
    join
    repeat (400) @(negedge clk);
    chk(mon_a.exp_q.size() == 0, "R2", mon_a.exp_q.size(), 0);
    chk(mon_b.exp_q.size() == 0, "R2", mon_b.exp_q.size(), 0);
    chk(sa == 1'b1, "R10", sa, 1);
    chk(sb == 1'b0, "R10", sb, 0);
    finished = 1;
    report();
    $finish;
  end
endmodule